// File: doc/BRIEF.md
# Direct-Mapped Cache with Exchange Victim Buffer

This block is a read-only first-level cache. Its main store is a direct-mapped array of single-word lines. A small fully associative buffer sits beside that array and keeps lines that the array has displaced. Every request is looked up in both structures in the same cycle. A hit in the main array answers on the next cycle. A hit only in the buffer swaps the two lines: the buffered line moves back into the array and the line that held its index takes the freed buffer slot. This costs one stall cycle.

When both structures miss, the block issues one line request to the next level and waits for the response. The returned line goes into the main array. The line it displaces is saved in the buffer, but only if that line is valid and its parity is intact. Each array line carries an even-parity bit that arrives with the fill. A tag match whose parity check fails is handled as a miss, so the line is fetched again. A static mode input selects whether the fresh copy of such a line is also placed in the buffer.

The buffer size `VC_N` can be as small as one entry. With one entry, LRU choice reduces to always reusing slot 0.

Top module: `vc_l1_cache`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and both `resp_valid` and `mem_req_valid` are 0. Every line in both structures starts invalid, so the first access to any address is a full miss.
- R2: A request accepted (`req_valid` and `req_ready` both 1 at a clock edge) that hits a parity-clean line in the direct-mapped array raises `resp_valid` with that line's data after the same edge. `req_ready` stays high and no next-level request is made.
- R3: A request that misses the array but hits the buffer drops `req_ready` for exactly one cycle and responds one edge later than an array hit, with no next-level request. After the swap, the requested line sits in the array and the former occupant sits in the buffer.
- R4: On a full miss, `mem_req_valid` pulses for a single cycle after the accepting edge, with `mem_req_addr` equal to the request address. The edge that samples `mem_resp_valid` writes the returned line into the array and raises `resp_valid` with `mem_resp_data`.
- R5: A fill or swap moves the displaced array line into the buffer only if that line is valid and its parity is correct. An invalid line produces no buffer write.
- R6: A buffer write chooses its slot in this order: a slot already holding the same address, then the lowest-numbered invalid slot, then the least recently used slot. The slot written becomes most recently used, and so does a slot used by a swap.
- R7: Parity is even. The stored bit comes from `mem_resp_par`, and a line is clean when that bit equals the XOR of its data bits. A tag match with bad parity is a miss and causes a refetch. A line with bad parity never enters the buffer.
- R8: With `pe_keep_good` = 1, a refetch caused by a parity miss also writes the returned line into the buffer, using the R6 slot choice. With `pe_keep_good` = 0, such a refetch leaves the buffer untouched.
- R9: The buffer never holds two valid entries with the same address.
- R10: `req_ready` is low whenever a swap or a fetch is in progress, and it rises only on the cycle that `resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_keep_good | input | 1 | 1: copy a line refetched after a parity miss into the buffer |
| req_valid | input | 1 | CPU read request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Line address of the request |
| resp_valid | output | 1 | Read data valid, one cycle |
| resp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Next-level line request, one-cycle pulse |
| mem_req_addr | output | ADDR_W | Line address requested from the next level |
| mem_resp_valid | input | 1 | Next-level line returned |
| mem_resp_data | input | DATA_W | Returned line data |
| mem_resp_par | input | 1 | Even-parity bit for the returned line |

## Verification
Several patterns are driven through the lookup:
- Repeated reads of one address separate array hits from misses.
- Ping-ponging between two addresses that share an index shows that lines are swapped rather than copied, since each return lands in the buffer.
- Rotating through four same-index addresses with a two-entry buffer forces replacement. Which address then misses tells LRU apart from slot-order or newest-first choice.
- Fills returned with a flipped parity bit, followed by rereads, are run in both settings of the mode input. Afterwards a probe of the entry that an extra buffer write would have displaced shows whether the corrupt line was kept out, whether the good copy was added, and whether a re-evicted copy reused its existing slot.

// File: rtl/vc_l1_cache.sv
module vc_l1_cache #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int VC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_keep_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data,
  input  logic              mem_resp_par
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int KW    = (VC_N > 1) ? $clog2(VC_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SWAP, S_WAIT} st_t;
  st_t state;

  logic              dm_v   [LINES];
  logic [TAG_W-1:0]  dm_tag [LINES];
  logic [DATA_W-1:0] dm_dat [LINES];
  logic              dm_p   [LINES];

  logic [VC_N-1:0]   vc_v;
  logic [ADDR_W-1:0] vc_a   [VC_N];
  logic [DATA_W-1:0] vc_dat [VC_N];
  logic              vc_p   [VC_N];
  logic [KW-1:0]     vc_age [VC_N];

  logic [ADDR_W-1:0] r_addr;
  logic [KW-1:0]     r_k;
  logic              r_pe;

  assign req_ready = (state == S_IDLE);

  wire [IDX_W-1:0] q_idx  = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag  = req_addr[ADDR_W-1:IDX_W];
  wire             q_tagm = dm_v[q_idx] && (dm_tag[q_idx] == q_tag);
  wire             q_perr = (^dm_dat[q_idx]) != dm_p[q_idx];
  wire             dm_hit = q_tagm && !q_perr;

  logic [VC_N-1:0] vc_match;
  logic [KW-1:0]   vc_k;
  always_comb begin
    vc_k = '0;
    for (int j = 0; j < VC_N; j++) begin
      vc_match[j] = vc_v[j] && (vc_a[j] == req_addr);
      if (vc_match[j]) vc_k = KW'(j);
    end
  end

  wire [IDX_W-1:0]  r_idx    = r_addr[IDX_W-1:0];
  wire [ADDR_W-1:0] occ_addr = {dm_tag[r_idx], r_idx};
  wire              occ_ok   = dm_v[r_idx] && ((^dm_dat[r_idx]) == dm_p[r_idx]);
  wire [ADDR_W-1:0] push_addr = occ_ok ? occ_addr : r_addr;
  wire              fill_push = (state == S_WAIT) && mem_resp_valid &&
                                (occ_ok || (r_pe && pe_keep_good));

  logic [VC_N-1:0] p_match;
  logic [KW-1:0]   sel;
  always_comb begin
    sel = '0;
    for (int j = 0; j < VC_N; j++)
      p_match[j] = vc_v[j] && (vc_a[j] == push_addr);
    for (int j = VC_N - 1; j >= 0; j--)
      if (vc_age[j] == KW'(VC_N - 1)) sel = KW'(j);
    for (int j = VC_N - 1; j >= 0; j--)
      if (!vc_v[j]) sel = KW'(j);
    for (int j = VC_N - 1; j >= 0; j--)
      if (p_match[j]) sel = KW'(j);
  end

  wire          touch  = (state == S_SWAP) || fill_push;
  wire [KW-1:0] t_slot = (state == S_SWAP) ? r_k : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      r_addr        <= '0;
      r_k           <= '0;
      r_pe          <= 1'b0;
      resp_valid    <= 1'b0;
      resp_data     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      vc_v          <= '0;
      for (int i = 0; i < LINES; i++) begin
        dm_v[i] <= 1'b0; dm_tag[i] <= '0; dm_dat[i] <= '0; dm_p[i] <= 1'b0;
      end
      for (int j = 0; j < VC_N; j++) begin
        vc_a[j] <= '0; vc_dat[j] <= '0; vc_p[j] <= 1'b0; vc_age[j] <= KW'(j);
      end
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          r_addr <= req_addr;
          r_k    <= vc_k;
          r_pe   <= q_tagm && q_perr;
          if (dm_hit) begin
            resp_valid <= 1'b1;
            resp_data  <= dm_dat[q_idx];
          end else if (|vc_match) begin
            state <= S_SWAP;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= req_addr;
            state         <= S_WAIT;
          end
        end
        S_SWAP: begin
          dm_v[r_idx]   <= 1'b1;
          dm_tag[r_idx] <= vc_a[r_k][ADDR_W-1:IDX_W];
          dm_dat[r_idx] <= vc_dat[r_k];
          dm_p[r_idx]   <= vc_p[r_k];
          if (occ_ok) begin
            vc_a[r_k]   <= occ_addr;
            vc_dat[r_k] <= dm_dat[r_idx];
            vc_p[r_k]   <= dm_p[r_idx];
            for (int j = 0; j < VC_N; j++)
              if (KW'(j) != r_k && p_match[j]) vc_v[j] <= 1'b0;
          end else begin
            vc_v[r_k] <= 1'b0;
          end
          resp_valid <= 1'b1;
          resp_data  <= vc_dat[r_k];
          state      <= S_IDLE;
        end
        S_WAIT: if (mem_resp_valid) begin
          dm_v[r_idx]   <= 1'b1;
          dm_tag[r_idx] <= r_addr[ADDR_W-1:IDX_W];
          dm_dat[r_idx] <= mem_resp_data;
          dm_p[r_idx]   <= mem_resp_par;
          if (fill_push) begin
            vc_v[sel]   <= 1'b1;
            vc_a[sel]   <= push_addr;
            vc_dat[sel] <= occ_ok ? dm_dat[r_idx] : mem_resp_data;
            vc_p[sel]   <= occ_ok ? dm_p[r_idx] : mem_resp_par;
          end
          resp_valid <= 1'b1;
          resp_data  <= mem_resp_data;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (touch)
        for (int j = 0; j < VC_N; j++) begin
          if (KW'(j) == t_slot) vc_age[j] <= '0;
          else if (vc_age[j] < vc_age[t_slot]) vc_age[j] <= vc_age[j] + 1'b1;
        end
    end
  end
endmodule

// File: rtl/vc_l1_cache_chk.sv
module vc_l1_cache_chk #(
  parameter int DATA_W = 32,
  parameter int VC_N   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_data,
  input logic              mem_req_valid,
  input logic              mem_resp_valid,
  input logic [DATA_W-1:0] mem_resp_data,
  input logic [VC_N-1:0]   vc_match
);
  a_r10_ready_rises_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> resp_valid);

  a_r10_busy_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r4_single_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  a_r4_fill_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_resp_valid && !req_ready && !mem_req_valid) |=>
      (resp_valid && resp_data == $past(mem_resp_data)));

  a_r2_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || !$past(req_ready)));

  a_r9_vc_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_match));
endmodule

bind vc_l1_cache vc_l1_cache_chk #(.DATA_W(DATA_W), .VC_N(VC_N)) u_chk (.*);

// File: tb/vc_l1_cache_tb.sv
`timescale 1ns/1ps
module vc_l1_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pe_keep_good = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_addr = '0;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        mem_req_valid;
  logic [9:0]  mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;
  logic        mem_resp_par = 1'b0;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] exp_q[$];
  bit          corrupt = 1'b0;

  localparam int DM = 0, VC = 1, MISS = 2;

  always #2 clk = ~clk;

  vc_l1_cache u_dut (
    .clk(clk), .rst_n(rst_n), .pe_keep_good(pe_keep_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .mem_resp_par(mem_resp_par)
  );

  function automatic logic [31:0] mem_f(input logic [9:0] a);
    return {a, 22'h0} ^ (32'h1234_5678 + 32'(a) * 32'd40503);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  // next-level memory model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [9:0] a;
        a = mem_req_addr;
        repeat (2) @(negedge clk);
        mem_resp_data  = mem_f(a);
        mem_resp_par   = (^mem_f(a)) ^ corrupt;
        corrupt        = 1'b0;
        mem_resp_valid = 1'b1;
        @(negedge clk);
        mem_resp_valid = 1'b0;
      end
    end
  end

  // monitor: compare read data against scoreboard (R2 R3 R4)
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R3/R4: unexpected response act=%h exp=none", resp_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (resp_data !== e) begin
          n_fail++;
          $display("FAIL R2/R3/R4: read data act=%h exp=%h", resp_data, e);
        end
      end
    end
  end

  task automatic access(input logic [9:0] a, input int kind, input string rq);
    int lat; bit memseen; bit rdy1; bit addr_ok; int cls;
    exp_q.push_back(mem_f(a));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; memseen = 0; addr_ok = 1; rdy1 = req_ready;
    while (!resp_valid && lat < 60) begin
      if (mem_req_valid) begin
        memseen = 1;
        if (mem_req_addr !== a) addr_ok = 0;
      end
      @(negedge clk);
      lat++;
    end
    if (memseen) cls = addr_ok ? MISS : 3;
    else if (lat == 1 && rdy1) cls = DM;
    else if (lat == 2 && !rdy1) cls = VC;
    else cls = 3;
    chk(cls == kind, rq, $sformatf("access %h outcome (0 dm,1 vc,2 miss)", a), cls, kind);
  endtask

  localparam logic [9:0] A = 10'h008, B = 10'h010, C = 10'h018, D = 10'h020;
  localparam logic [9:0] E = 10'h001, F = 10'h002, H = 10'h003, I = 10'h00B;

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(resp_valid === 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
    chk(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);

    access(A, MISS, "R1 R4");
    access(A, DM,   "R2");
    access(B, MISS, "R4 R5");
    access(A, VC,   "R3 R5");
    access(B, VC,   "R3 R10");
    access(C, MISS, "R6");
    access(D, MISS, "R6");
    access(A, MISS, "R6");
    access(B, MISS, "R6");
    access(D, VC,   "R6");
    access(C, MISS, "R6");
    access(E, MISS, "R4");
    access(E, DM,   "R2");

    pe_keep_good = 1'b0;
    corrupt = 1'b1;
    access(F, MISS, "R5 R7");
    access(F, MISS, "R7");
    access(F, DM,   "R7");
    access(B, VC,   "R7 R8");

    pe_keep_good = 1'b1;
    corrupt = 1'b1;
    access(H, MISS, "R7");
    access(H, MISS, "R8");
    access(D, MISS, "R8");
    access(I, MISS, "R9");
    access(B, VC,   "R6 R9");
    access(H, VC,   "R3 R9");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10: watchdog expired act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule